// File: doc/BRIEF.md
# Serial Transmit FIFO Level Interrupt Controller

This block is the register and interrupt front end of a FIFO-buffered serial transmitter. It holds the port's 8-bit control register and a mode register with a bit-rate prescaler select and a transmit trigger select. It keeps a count of how many bytes wait in a 16-entry transmit FIFO and raises a data-empty flag when that count falls to the trigger level. The FIFO byte storage, the line shifter and the receive side sit outside the block.

Bytes enter the FIFO through CPU writes to the data address or through a one-cycle DMA write strobe. They leave when the shifter pulses its load strobe. The flag is set only on a load. Software clears it in two steps: it reads the flag as 1, then writes 0 once the count is back above the trigger. A DMA write clears the flag at once. The transmit interrupt is the flag gated by the interrupt enable bit. The prescaler does not make a divided clock. It makes a single-cycle enable pulse at the selected rate.

Top module: `sertx_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the control and mode registers read 0x00. The status register reads 0x00, fifo_cnt is 0 and txi_irq is 0.
- R2: The control register at address 0 has this layout, MSB first: transmit interrupt enable, receive interrupt enable, transmit enable, receive enable, multiprocessor interrupt enable, reserved, clock source [1:0]. The CPU can read and write it at any time. Bit 2 always reads 0. tx_en, rx_en, rx_ie, mp_ie and clk_src show bits 5, 4, 6, 3 and 1:0.
- R3: Mode register (address 1) bits [1:0] select the tick rate: 00 gives a pulse every cycle, 01 every 4 cycles, 10 every 16 and 11 every 64. Each pulse lasts one cycle.
- R4: A CPU write to address 3 or a dma_wr pulse adds one entry. shift_ld removes one entry when the count is not zero. Pops are applied before pushes in the same cycle. Pushes into a full FIFO are dropped, so the count never exceeds 16. The count reads back in status bits [7:3].
- R5: Mode register bits [5:4] select the trigger level: 00 is 1 byte, 01 is 2, 10 is 4 and 11 is 8.
- R6: A shift_ld that removes an entry sets the data-empty flag (status bit 0, also on tde_flag) when the remaining count is at or below the trigger. The flag changes on no other event.
- R7: txi_irq is high exactly when the flag is set and control bit 7 is 1. Clearing bit 7 drops the request while the flag stays set.
- R8: A status read that returns the flag as 1 arms a clear. A later status write with bit 0 = 0 clears the flag if the count is above the trigger at that time.
- R9: A status write of 0 clears nothing unless it was armed since the flag was last set. A write of 0 while the count is at or below the trigger also clears nothing. Writing 1 never sets the flag.
- R10: A dma_wr pulse clears the flag on the next cycle. A load that sets the flag in the same cycle takes priority over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | 0 control, 1 mode, 2 status, 3 FIFO data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational, 0 when not selected |
| dma_wr | input | 1 | DMA byte write into the transmit FIFO |
| shift_ld | input | 1 | Shifter takes one byte from the FIFO |
| txi_irq | output | 1 | Transmit data-empty interrupt request |
| tde_flag | output | 1 | Data-empty flag |
| tick | output | 1 | Prescaler enable pulse |
| tx_en | output | 1 | Transmit enable |
| rx_en | output | 1 | Receive enable |
| rx_ie | output | 1 | Receive interrupt enable |
| mp_ie | output | 1 | Multiprocessor interrupt enable |
| clk_src | output | 2 | Clock source select |
| fifo_cnt | output | 5 | Transmit FIFO fill count |

## Verification
On every cycle the assertions check the following:
- the fill count stays bounded and holds when the FIFO is full and nothing pops;
- the reserved control bit reads 0;
- an interrupt never appears without its enable;
- the flag only rises after a load;
- the flag falls after a DMA write;
- the flag is never set by a write.

Some behaviours need bench scenarios because they depend on history:
- the two-step clear, including rejected writes before the read or below the trigger;
- the exact trigger thresholds for each code;
- the tick count of each prescaler rate over a window.

A random mix of pushes, loads, DMA writes and register accesses is compared against a requirement-level model.

// File: rtl/sertx_pkg.sv
package sertx_pkg;

    localparam int FIFO_DEPTH = 16;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int PRE_STAGES = 3;
    localparam int PRE_W      = 2 * PRE_STAGES;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_MODE = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_DATA = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic       tie;
        logic       rie;
        logic       te;
        logic       re;
        logic       mpie;
        logic       rsvd;
        logic [1:0] cke;
    } ctrl_t;

    typedef struct packed {
        logic [1:0] rsv_hi;
        logic [1:0] trig;
        logic [1:0] rsv_lo;
        logic [1:0] pre;
    } mode_t;

    function automatic logic [CNT_W-1:0] trig_level(input logic [1:0] code);
        return CNT_W'(1) << code;
    endfunction

    function automatic logic [PRE_W-1:0] pre_mask(input logic [1:0] sel);
        logic [PRE_W-1:0] m;
        m = '0;
        for (int i = 0; i < PRE_W; i++) begin
            if (i < 2 * int'(sel)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/sertx_prescale.sv
module sertx_prescale
    import sertx_pkg::*;
#(
    parameter int W = PRE_W
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [W-1:0] div_q;
    logic [W-1:0] mask;

    always_ff @(posedge clk) begin
        if (rst) div_q <= '0;
        else     div_q <= div_q + W'(1);
    end

    assign mask = W'(pre_mask(sel));
    assign tick = ((div_q & mask) == mask);
endmodule

// File: rtl/sertx_fill.sv
module sertx_fill
    import sertx_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH,
    parameter int CW    = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push_cpu,
    input  logic          push_dma,
    input  logic          pop,
    output logic [CW-1:0] cnt,
    output logic          pop_ok
);
    logic [CW:0] acc;

    assign pop_ok = pop && (cnt != '0);

    always_comb begin
        acc = {1'b0, cnt};
        if (pop_ok) acc = acc - (CW+1)'(1);
        if (push_cpu && acc < (CW+1)'(DEPTH)) acc = acc + (CW+1)'(1);
        if (push_dma && acc < (CW+1)'(DEPTH)) acc = acc + (CW+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= acc[CW-1:0];
    end
endmodule

// File: rtl/sertx_flag.sv
module sertx_flag (
    input  logic clk,
    input  logic rst,
    input  logic set_ev,
    input  logic dma_clr,
    input  logic rd_stat,
    input  logic wr_stat,
    input  logic wr_bit0,
    input  logic above_trig,
    output logic flag,
    output logic armed
);
    logic flag_n, arm_n;

    always_comb begin
        flag_n = flag;
        arm_n  = armed;
        if (rd_stat && flag) arm_n = 1'b1;
        if (wr_stat && !wr_bit0 && armed && above_trig) flag_n = 1'b0;
        if (dma_clr) flag_n = 1'b0;
        if (set_ev) begin
            flag_n = 1'b1;
            arm_n  = 1'b0;
        end
        if (!flag_n) arm_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b0;
            armed <= 1'b0;
        end else begin
            flag  <= flag_n;
            armed <= arm_n;
        end
    end
endmodule

// File: rtl/sertx_irq_ctrl.sv
module sertx_irq_ctrl
    import sertx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic             dma_wr,
    input  logic             shift_ld,
    output logic             txi_irq,
    output logic             tde_flag,
    output logic             tick,
    output logic             tx_en,
    output logic             rx_en,
    output logic             rx_ie,
    output logic             mp_ie,
    output logic [1:0]       clk_src,
    output logic [CNT_W-1:0] fifo_cnt
);
    ctrl_t     ctrl_q;
    mode_t     mode_q;
    reg_addr_e addr;
    logic      wr_ctrl, wr_mode, wr_stat, rd_stat, wr_data;
    logic      pop_ok, set_ev, above_trig, armed;
    logic [CNT_W-1:0] trig;
    logic [7:0] stat_word;

    assign addr    = reg_addr_e'(bus_addr);
    assign wr_ctrl = bus_sel &&  bus_wr && addr == ADDR_CTRL;
    assign wr_mode = bus_sel &&  bus_wr && addr == ADDR_MODE;
    assign wr_stat = bus_sel &&  bus_wr && addr == ADDR_STAT;
    assign rd_stat = bus_sel && !bus_wr && addr == ADDR_STAT;
    assign wr_data = bus_sel &&  bus_wr && addr == ADDR_DATA;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            mode_q <= '0;
        end else begin
            if (wr_ctrl) begin
                ctrl_q      <= ctrl_t'(bus_wdata);
                ctrl_q.rsvd <= 1'b0;
            end
            if (wr_mode) begin
                mode_q      <= '0;
                mode_q.trig <= bus_wdata[5:4];
                mode_q.pre  <= bus_wdata[1:0];
            end
        end
    end

    sertx_prescale u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (mode_q.pre),
        .tick (tick)
    );

    sertx_fill u_fill (
        .clk      (clk),
        .rst      (rst),
        .push_cpu (wr_data),
        .push_dma (dma_wr),
        .pop      (shift_ld),
        .cnt      (fifo_cnt),
        .pop_ok   (pop_ok)
    );

    assign trig       = trig_level(mode_q.trig);
    assign set_ev     = pop_ok && ((fifo_cnt - CNT_W'(1)) <= trig);
    assign above_trig = fifo_cnt > trig;

    sertx_flag u_flag (
        .clk        (clk),
        .rst        (rst),
        .set_ev     (set_ev),
        .dma_clr    (dma_wr),
        .rd_stat    (rd_stat),
        .wr_stat    (wr_stat),
        .wr_bit0    (bus_wdata[0]),
        .above_trig (above_trig),
        .flag       (tde_flag),
        .armed      (armed)
    );

    always_comb begin
        stat_word              = '0;
        stat_word[0]           = tde_flag;
        stat_word[7 -: CNT_W]  = fifo_cnt;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            case (addr)
                ADDR_CTRL: bus_rdata = ctrl_q;
                ADDR_MODE: bus_rdata = mode_q;
                ADDR_STAT: bus_rdata = stat_word;
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign txi_irq = tde_flag & ctrl_q.tie;
    assign tx_en   = ctrl_q.te;
    assign rx_en   = ctrl_q.re;
    assign rx_ie   = ctrl_q.rie;
    assign mp_ie   = ctrl_q.mpie;
    assign clk_src = ctrl_q.cke;
endmodule

// File: rtl/sertx_irq_ctrl_chk.sv
module sertx_irq_ctrl_chk
    import sertx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [1:0]       bus_addr,
    input logic [7:0]       bus_rdata,
    input logic             dma_wr,
    input logic             shift_ld,
    input logic             txi_irq,
    input logic             tde_flag,
    input logic             tie,
    input logic [CNT_W-1:0] fifo_cnt
);
    // R4
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        fifo_cnt <= CNT_W'(FIFO_DEPTH));

    // R4
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (fifo_cnt == CNT_W'(FIFO_DEPTH) && !shift_ld) |=> fifo_cnt == CNT_W'(FIFO_DEPTH));

    // R2
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_wr && bus_addr == 2'd0) |-> !bus_rdata[2]);

    // R7
    irq_needs_tie_chk: assert property (@(posedge clk) disable iff (rst)
        !tie |-> !txi_irq);

    // R6
    flag_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(tde_flag) |-> $past(shift_ld));

    // R9
    no_write_set_chk: assert property (@(posedge clk) disable iff (rst)
        (!tde_flag && !shift_ld) |=> !tde_flag);

    // R10
    dma_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (dma_wr && !shift_ld) |=> !tde_flag);
endmodule

bind sertx_irq_ctrl sertx_irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_rdata (bus_rdata),
    .dma_wr    (dma_wr),
    .shift_ld  (shift_ld),
    .txi_irq   (txi_irq),
    .tde_flag  (tde_flag),
    .tie       (ctrl_q.tie),
    .fifo_cnt  (fifo_cnt)
);

// File: tb/sertx_irq_ctrl_test.sv
module sertx_irq_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       dma_wr = 1'b0, shift_ld = 1'b0;
    logic       txi_irq, tde_flag, tick, tx_en, rx_en, rx_ie, mp_ie;
    logic [1:0] clk_src;
    logic [4:0] fifo_cnt;

    int tests = 0, fails = 0;
    logic [7:0] m_ctrl = 8'd0;
    logic [1:0] m_pre = 2'd0, m_trig = 2'd0;
    int         m_cnt = 0;
    logic       m_flag = 1'b0, m_arm = 1'b0;
    bit         done = 1'b0;

    always #5 clk = ~clk;

    sertx_irq_ctrl uut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dma_wr(dma_wr), .shift_ld(shift_ld), .txi_irq(txi_irq),
        .tde_flag(tde_flag), .tick(tick), .tx_en(tx_en), .rx_en(rx_en),
        .rx_ie(rx_ie), .mp_ie(mp_ie), .clk_src(clk_src), .fifo_cnt(fifo_cnt)
    );

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int trig_of(input logic [1:0] c);
        return 1 << c;
    endfunction

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        case (a)
            2'd0: return m_ctrl;
            2'd1: return {2'b00, m_trig, 2'b00, m_pre};
            2'd2: return {5'(m_cnt), 2'b00, m_flag};
            default: return 8'd0;
        endcase
    endfunction

    // one cycle: drive at negedge, update model at the edge, compare after it
    task automatic op(input bit s, input bit w, input logic [1:0] a,
                      input logic [7:0] d, input bit dm, input bit sh);
        int  c;
        bit  pop, pc, set_ev;
        logic nf, na;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        dma_wr = dm; shift_ld = sh;
        #1;
        if (s && !w) check("R2/R4 read", int'(bus_rdata), int'(exp_read(a)));
        pc  = s && w && a == 2'd3;
        pop = sh && m_cnt > 0;
        c = m_cnt - (pop ? 1 : 0);
        if (pc && c < 16) c++;
        if (dm && c < 16) c++;
        set_ev = pop && (m_cnt - 1) <= trig_of(m_trig);
        nf = m_flag; na = m_arm;
        if (s && !w && a == 2'd2 && m_flag) na = 1'b1;
        if (s && w && a == 2'd2 && !d[0] && m_arm && m_cnt > trig_of(m_trig)) nf = 1'b0;
        if (dm) nf = 1'b0;
        if (set_ev) begin nf = 1'b1; na = 1'b0; end
        if (!nf) na = 1'b0;
        @(posedge clk);
        #1;
        m_cnt = c; m_flag = nf; m_arm = na;
        if (s && w && a == 2'd0) m_ctrl = d & 8'hFB;
        if (s && w && a == 2'd1) begin m_pre = d[1:0]; m_trig = d[5:4]; end
        bus_sel = 1'b0; bus_wr = 1'b0; dma_wr = 1'b0; shift_ld = 1'b0;
        check("R4 count", int'(fifo_cnt), m_cnt);
        check("R6 flag", int'(tde_flag), int'(m_flag));
        check("R7 irq", int'(txi_irq), int'(m_flag & m_ctrl[7]));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int r, ticks;
        bit prev;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        check("R1 irq", int'(txi_irq), 0);
        check("R1 count", int'(fifo_cnt), 0);
        for (int a = 0; a < 3; a++) op(1, 0, 2'(a), 8'd0, 0, 0);

        // R2 layout and reserved bit
        op(1, 1, 2'd0, 8'hFF, 0, 0);
        op(1, 0, 2'd0, 8'd0, 0, 0);
        check("R2 tx_en", int'(tx_en), 1);
        check("R2 clk_src", int'(clk_src), 3);
        op(1, 1, 2'd0, 8'h5A, 0, 0);
        check("R2 rx_ie", int'(rx_ie), 1);
        check("R2 rx_en", int'(rx_en), 1);
        check("R2 mp_ie", int'(mp_ie), 1);
        check("R2 tx_en low", int'(tx_en), 0);
        op(1, 1, 2'd0, 8'h00, 0, 0);

        // R4 saturation at 16
        for (int i = 0; i < 20; i++) op(1, 1, 2'd3, 8'h11, 0, 0);
        check("R4 full", int'(fifo_cnt), 16);

        // R5/R6 trigger 4: no flag above 4, flag when 4 remain
        op(1, 1, 2'd1, 8'h20, 0, 0);
        for (int i = 0; i < 11; i++) op(0, 0, 2'd0, 8'd0, 0, 1);
        check("R5 above trigger", int'(tde_flag), 0);
        op(0, 0, 2'd0, 8'd0, 0, 1);
        check("R5 at trigger", int'(tde_flag), 1);
        check("R7 no enable", int'(txi_irq), 0);
        op(1, 1, 2'd0, 8'h80, 0, 0);
        check("R7 enabled", int'(txi_irq), 1);

        // R9 unarmed write, R8 handshake
        op(1, 1, 2'd2, 8'h00, 0, 0);
        check("R9 unarmed", int'(tde_flag), 1);
        op(1, 0, 2'd2, 8'h00, 0, 0);
        op(1, 1, 2'd2, 8'h00, 0, 0);
        check("R9 at trigger", int'(tde_flag), 1);
        op(1, 1, 2'd3, 8'h22, 0, 0);
        op(1, 1, 2'd2, 8'h01, 0, 0);
        check("R9 write one", int'(tde_flag), 1);
        op(1, 1, 2'd2, 8'h00, 0, 0);
        check("R8 cleared", int'(tde_flag), 0);
        op(1, 1, 2'd2, 8'h01, 0, 0);
        check("R9 no set", int'(tde_flag), 0);

        // R10 DMA clear
        op(0, 0, 2'd0, 8'd0, 0, 1);
        check("R10 set first", int'(tde_flag), 1);
        op(0, 0, 2'd0, 8'd0, 1, 0);
        check("R10 dma clear", int'(tde_flag), 0);
        check("R7 irq off", int'(txi_irq), 0);

        // R3 prescaler rates over a 128-cycle window
        for (int s = 0; s < 4; s++) begin
            op(1, 1, 2'd1, 8'(s), 0, 0);
            ticks = 0; prev = 1'b0;
            for (int k = 0; k < 128; k++) begin
                @(negedge clk);
                if (tick) ticks++;
                if (s != 0 && tick && prev) check("R3 single pulse", 1, 0);
                prev = tick;
            end
            check("R3 rate", ticks, 128 >> (2 * s));
        end

        // random mix
        for (int i = 0; i < 3000; i++) begin
            r = int'($urandom % 16);
            case (r)
                0, 1, 2, 3: op(1, 1, 2'd3, 8'($urandom), 0, 0);
                4, 5, 6:    op(0, 0, 2'd0, 8'd0, 0, 1);
                7:          op(0, 0, 2'd0, 8'd0, 1, 0);
                8, 9:       op(1, 0, 2'($urandom), 8'd0, 0, 0);
                10, 11:     op(1, 1, 2'd2, 8'($urandom % 8 == 0), 0, 0);
                12:         op(1, 1, 2'd0, 8'($urandom), 0, 0);
                13:         op(1, 1, 2'd1, 8'($urandom), 0, 0);
                14:         op(0, 0, 2'd0, 8'd0, 0, 0);
                default:    op(0, 0, 2'd0, 8'd0, 1, 1);
            endcase
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule